// File: doc/BRIEF.md
# SDRAM Mode Register Programmer

This block sits between a CPU-side bus and two SDRAM areas. A CPU write that lands in one of two reserved address windows is turned into an SDRAM mode-register-set (MRS) sequence for the area that owns the window. The data bus plays no part: the 16-bit mode value is the distance of the write address from the start of its window. That distance is scaled down by the SDRAM bus width, with a shift of 2 for a 32-bit bus and a shift of 1 for a 16-bit bus. The mode register exists only on the SDRAM side. No copy of it is kept here, and a read of a window returns nothing.

The sequence is handled by a state machine with six states:
- `ST_IDLE`: waits for a window write (transition IDLE→PALL).
- `ST_PALL`: issues a precharge-all with the address bit 10 line high (PALL→TRP).
- `ST_TRP`: holds NOP for `TRP` cycles (TRP→MRS when the wait counter reaches its limit).
- `ST_MRS`: drives RAS, CAS and WE low for one cycle with the mode value on the address pins (MRS→TMRD). On this edge it marks the area as programmed.
- `ST_TMRD`: holds NOP for `TMRD` cycles (TMRD→DONE).
- `ST_DONE`: returns bus ready for one cycle (DONE→IDLE).

Normal accesses to an area are granted only in `ST_IDLE`, and only once that area has been programmed.

Top module: `sdram_mode_prog`

## Requirements
- R1: After reset both chip selects are high, RAS/CAS/WE are high, `bus_ready` and `norm_grant` are low and both `area_done` bits are 0.
- R2: With `width32`=1, a write to window base + 4·X drives X on `sd_addr` during the MRS cycle (RAS, CAS, WE all low).
- R3: With `width32`=0, a write to window base + 2·X drives X on `sd_addr` during the MRS cycle.
- R4: A write to the window at `BASE_A` (area index 0) asserts only `sd_cs_n[0]`, and a write to the window at `BASE_B` (area index 1) asserts only `sd_cs_n[1]`. Both the precharge and the MRS go to the selected chip select. At no time are both chip selects low.
- R5: The sequence first issues one precharge-all cycle (RAS=0, CAS=1, WE=0, `sd_addr[10]`=1). This is followed by exactly `TRP` NOP cycles and then the MRS cycle, so the MRS comes `TRP`+1 cycles after the precharge.
- R6: `bus_ready` rises `TMRD`+1 cycles after the MRS cycle and stays high for a single cycle.
- R7: `area_done[i]` becomes 1 in the cycle after area i's MRS. It then stays 1 until the next reset, which clears it.
- R8: A request outside both windows asserts `norm_grant` only while idle and only if `area_done[bus_addr[AREA_BIT]]` is 1. Otherwise it is stalled.
- R9: `width32` is sampled only when the sequence starts. Changing it during a sequence leaves the mode value of that sequence unchanged.
- R10: A read (`bus_we`=0) to a window returns `bus_ready` in the same cycle. It issues no SDRAM command and leaves `area_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | CPU request, held until `bus_ready` for window writes |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | CPU byte address |
| width32 | input | 1 | SDRAM bus width: 1 = 32-bit, 0 = 16-bit |
| bus_ready | output | 1 | Completion of a window access |
| norm_grant | output | 1 | Normal SDRAM access may proceed |
| sd_cs_n | output | 2 | Chip selects, index 0 for the `BASE_A` area and index 1 for the `BASE_B` area |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | MODE_W | SDRAM address pins |
| area_done | output | 2 | Per-area "mode programmed" flags |

## Verification
The bench builds the block with `TRP`=4, so the precharge-to-MRS gap differs from the default and from `TMRD`. It keeps a 26-bit address, an 18-bit window and a 16-bit mode. With an 18-bit window, the all-ones value 16'hFFFF fits at a shift of 2, so both edges of the mode range can be reached in both bus widths. A fresh reset in the middle of the run allows the case where one area is programmed and the other is still stalled.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_TRP,
        ST_MRS,
        ST_TMRD,
        ST_DONE
    } sdm_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdm_cmd_t;

    localparam sdm_cmd_t CMD_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdm_cmd_t CMD_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdm_cmd_t CMD_MRS  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdm_win_decode.sv
module sdm_win_decode #(
    parameter int              ADDR_W   = 26,
    parameter int              WIN_BITS = 18,
    parameter int              MODE_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_A = 26'h0C0_0000,
    parameter logic [ADDR_W-1:0] BASE_B = 26'h1C0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              width32,
    output logic              hit,
    output logic              area,
    output logic [MODE_W-1:0] mode
);
    localparam int N_WIN = 2;
    localparam logic [N_WIN-1:0][ADDR_W-1:0] BASES = {BASE_B, BASE_A};

    logic [N_WIN-1:0]                 win_hit;
    logic [N_WIN-1:0][WIN_BITS-1:0]   win_off;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        logic [ADDR_W-1:0] diff;
        assign diff       = addr - BASES[g];
        assign win_hit[g] = ~|diff[ADDR_W-1:WIN_BITS];
        assign win_off[g] = diff[WIN_BITS-1:0];
    end

    logic [WIN_BITS-1:0] off_sel;
    logic [WIN_BITS-1:0] off_shr;

    always_comb begin
        hit     = |win_hit;
        area    = win_hit[1];
        off_sel = win_hit[1] ? win_off[1] : win_off[0];
        off_shr = width32 ? (off_sel >> 2) : (off_sel >> 1);
        mode    = MODE_W'(off_shr);
    end

endmodule

// File: rtl/sdm_wait_cnt.sv
module sdm_wait_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign last = (cnt == limit - 1'b1);

endmodule

// File: rtl/sdm_area_flags.sv
module sdm_area_flags #(
    parameter int N_AREAS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic               set_idx,
    output logic [N_AREAS-1:0] done
);
    for (genvar g = 0; g < N_AREAS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                                   done[g] <= 1'b0;
            else if (set_en && (int'(set_idx) == g))      done[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/sdram_mode_prog.sv
module sdram_mode_prog #(
    parameter int              ADDR_W   = 26,
    parameter int              WIN_BITS = 18,
    parameter int              MODE_W   = 16,
    parameter int              AREA_BIT = 24,
    parameter int              PALL_BIT = 10,
    parameter int              TRP      = 3,
    parameter int              TMRD     = 2,
    parameter logic [ADDR_W-1:0] BASE_A = 26'h0C0_0000,
    parameter logic [ADDR_W-1:0] BASE_B = 26'h1C0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              width32,
    output logic              bus_ready,
    output logic              norm_grant,
    output logic [1:0]        sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [MODE_W-1:0] sd_addr,
    output logic [1:0]        area_done
);
    import sdm_pkg::*;

    localparam int MAX_WAIT = (TRP > TMRD) ? TRP : TMRD;
    localparam int CW       = $clog2(MAX_WAIT + 1);

    sdm_state_e        state, state_nx;
    logic              win_hit, win_area;
    logic [MODE_W-1:0] win_mode;
    logic              area_q;
    logic [MODE_W-1:0] mode_q;
    logic              wait_last;
    logic [CW-1:0]     wait_lim;
    sdm_cmd_t          cmd;
    logic              start;

    sdm_win_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .MODE_W(MODE_W),
        .BASE_A(BASE_A), .BASE_B(BASE_B)
    ) u_dec (
        .addr(bus_addr), .width32(width32),
        .hit(win_hit), .area(win_area), .mode(win_mode)
    );

    assign wait_lim = (state == ST_TRP) ? CW'(TRP) : CW'(TMRD);

    sdm_wait_cnt #(.CW(CW)) u_wait (
        .clk(clk), .rst_n(rst_n),
        .clr(state == ST_PALL || state == ST_MRS),
        .limit(wait_lim), .last(wait_last)
    );

    sdm_area_flags #(.N_AREAS(2)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_en(state == ST_MRS), .set_idx(area_q),
        .done(area_done)
    );

    assign start = (state == ST_IDLE) && bus_req && bus_we && win_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture: width and window sampled only at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_q <= 1'b0;
            mode_q <= '0;
        end else if (start) begin
            area_q <= win_area;
            mode_q <= win_mode;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_PALL;
            ST_PALL:                state_nx = ST_TRP;
            ST_TRP:  if (wait_last) state_nx = ST_MRS;
            ST_MRS:                 state_nx = ST_TMRD;
            ST_TMRD: if (wait_last) state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd        = CMD_NOP;
        sd_cs_n    = 2'b11;
        sd_addr    = '0;
        bus_ready  = 1'b0;
        norm_grant = 1'b0;
        unique case (state)
            ST_IDLE: begin
                bus_ready  = bus_req && !bus_we && win_hit;
                norm_grant = bus_req && !win_hit && area_done[bus_addr[AREA_BIT]];
            end
            ST_PALL: begin
                cmd               = CMD_PALL;
                sd_cs_n[area_q]   = 1'b0;
                sd_addr[PALL_BIT] = 1'b1;
            end
            ST_MRS: begin
                cmd             = CMD_MRS;
                sd_cs_n[area_q] = 1'b0;
                sd_addr         = mode_q;
            end
            ST_DONE: bus_ready = 1'b1;
            default: ;
        endcase
    end

    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdm_mode_prog_chk.sv
module sdm_mode_prog_chk #(
    parameter int ADDR_W   = 26,
    parameter int MODE_W   = 16,
    parameter int AREA_BIT = 24,
    parameter int PALL_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              norm_grant,
    input logic [1:0]        sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [MODE_W-1:0] sd_addr,
    input logic [1:0]        area_done
);
    logic is_nop, is_pall, is_mrs;
    assign is_nop  = (sd_cs_n == 2'b11);
    assign is_pall = !is_nop && !sd_ras_n && sd_cas_n && !sd_we_n;
    assign is_mrs  = !is_nop && !sd_ras_n && !sd_cas_n && !sd_we_n;

    a_r4_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sd_cs_n) <= 1);

    a_r5_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> sd_addr[PALL_BIT]);

    a_r5_pall_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |=> is_nop);

    a_r5_mrs_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> $past(is_nop));

    a_r6_no_ready_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> !bus_ready);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(area_done) & ~area_done) == 2'b00));

    for (genvar g = 0; g < 2; g++) begin : g_area
        a_r7_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(area_done[g]) |-> $past(is_mrs && !sd_cs_n[g]));
    end

    a_r8_grant_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        norm_grant |-> area_done[bus_addr[AREA_BIT]]);

    a_r10_read_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |-> is_nop);

endmodule

bind sdram_mode_prog sdm_mode_prog_chk #(
    .ADDR_W(ADDR_W), .MODE_W(MODE_W), .AREA_BIT(AREA_BIT), .PALL_BIT(PALL_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_ready(bus_ready), .norm_grant(norm_grant),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .area_done(area_done)
);

// File: tb/sdram_mode_prog_tb.sv
module sdram_mode_prog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 26;
    localparam int MODE_W = 16;
    localparam int TRP    = 4;
    localparam int TMRD   = 2;
    localparam logic [ADDR_W-1:0] BASE_A = 26'h0C0_0000;
    localparam logic [ADDR_W-1:0] BASE_B = 26'h1C0_0000;
    localparam logic [ADDR_W-1:0] NORM_A = 26'h000_1000;
    localparam logic [ADDR_W-1:0] NORM_B = 26'h100_1000;

    // {area, width32, flip width mid-sequence, mode value}
    localparam int NV = 7;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 16'h0230},
        {1'b0, 1'b0, 1'b0, 16'h0032},
        {1'b1, 1'b1, 1'b0, 16'hFFFF},
        {1'b1, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b0, 1'b0, 16'hFFFF},
        {1'b1, 1'b1, 1'b1, 16'h5A5A},
        {1'b0, 1'b0, 1'b1, 16'h0123}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_req, bus_we, width32;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_ready, norm_grant;
    logic [1:0]        sd_cs_n, area_done;
    logic              sd_ras_n, sd_cas_n, sd_we_n;
    logic [MODE_W-1:0] sd_addr;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_mode_prog #(.TRP(TRP), .TMRD(TMRD), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .width32(width32), .bus_ready(bus_ready),
        .norm_grant(norm_grant), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .area_done(area_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; width32 = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_mrs(input bit area, input bit w32, input bit flip,
                           input logic [15:0] val, inout logic [1:0] exp_done);
        int          pall_c = -1, mrs_c = -1, rdy_c = -1;
        logic [1:0]  exp_cs;
        exp_cs = area ? 2'b01 : 2'b10;
        @(negedge clk);
        width32  = w32;
        bus_we   = 1'b1;
        bus_req  = 1'b1;
        bus_addr = (area ? BASE_B : BASE_A) + (ADDR_W'(val) << (w32 ? 2 : 1));
        for (int c = 1; c < 60 && rdy_c < 0; c++) begin
            @(negedge clk);
            if (c == 2 && flip) width32 = ~w32;
            if (sd_cs_n != 2'b11 && sd_cas_n && pall_c < 0) begin
                pall_c = c;
                check(sd_cs_n == exp_cs, "R4 pall cs", sd_cs_n, exp_cs);
                check(!sd_ras_n && !sd_we_n && sd_addr[10], "R5 pall pins",
                      {sd_ras_n, sd_we_n, sd_addr[10]}, 3'b001);
            end
            if (sd_cs_n != 2'b11 && !sd_cas_n && mrs_c < 0) begin
                mrs_c = c;
                check(sd_cs_n == exp_cs, "R4 mrs cs", sd_cs_n, exp_cs);
                check(!sd_ras_n && !sd_we_n, "R2 mrs pins", {sd_ras_n, sd_we_n}, 2'b00);
                check(sd_addr == val, w32 ? (flip ? "R9 mode" : "R2 mode") : (flip ? "R9 mode" : "R3 mode"),
                      sd_addr, val);
            end
            if (mrs_c > 0 && c == mrs_c + 1) begin
                exp_done[area] = 1'b1;
                check(area_done == exp_done, "R7 flag set", area_done, exp_done);
            end
            if (bus_ready) begin
                rdy_c = c;
                bus_req = 1'b0;
            end
        end
        check(pall_c == 1, "R5 pall first", pall_c, 1);
        check(mrs_c - pall_c == TRP + 1, "R5 trp gap", mrs_c - pall_c, TRP + 1);
        check(rdy_c - mrs_c == TMRD + 1, "R6 ready delay", rdy_c - mrs_c, TMRD + 1);
        @(negedge clk);
        check(!bus_ready, "R6 ready one cycle", bus_ready, 0);
        check(area_done == exp_done, "R7 flags hold", area_done, exp_done);
    endtask

    task automatic norm_try(input logic [ADDR_W-1:0] a, input bit exp, input string req);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        check(norm_grant == exp, req, norm_grant, exp);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] exp_done;
        do_reset();
        @(negedge clk);
        check(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n, "R1 pins idle",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'h1f);
        check(!bus_ready && !norm_grant, "R1 ready/grant", {bus_ready, norm_grant}, 0);
        check(area_done == 2'b00, "R1 flags", area_done, 0);
        norm_try(NORM_A, 1'b0, "R8 stall unprogrammed");

        exp_done = 2'b00;
        for (int i = 0; i < NV; i++) begin
            run_mrs(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0], exp_done);
        end
        norm_try(NORM_A, 1'b1, "R8 grant area A");
        norm_try(NORM_B, 1'b1, "R8 grant area B");

        // R10: window read
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = BASE_A + 26'h40;
        #1;
        check(bus_ready, "R10 read ready", bus_ready, 1);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(sd_cs_n == 2'b11, "R10 no command", sd_cs_n, 2'b11);
        end
        bus_req = 1'b0;
        check(area_done == exp_done, "R10 flags kept", area_done, exp_done);

        // R7/R8: reset clears, one area programmed only
        do_reset();
        @(negedge clk);
        check(area_done == 2'b00, "R7 reset clears", area_done, 0);
        exp_done = 2'b00;
        run_mrs(1'b1, 1'b1, 1'b0, 16'h0021, exp_done);
        norm_try(NORM_B, 1'b1, "R8 grant programmed B");
        norm_try(NORM_A, 1'b0, "R8 stall unprogrammed A");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule